// File: doc/BRIEF.md
# Selectable PD/PI/PID Fuzzy Controller Datapath

This block is the arithmetic around a pair of fuzzy inference channels in a sampled feedback loop. On every sample strobe it takes the setpoint and the measured plant output and registers the control error and the change in that error since the previous strobe. It then scales both by programmable gains and presents them to two external inference engines. One engine acts as a proportional-derivative channel. The other acts as a proportional-integral channel, because its output is later accumulated.

The inference engines return their results on their own result ports, each with a valid strobe, in any order and after any delay. The block waits until both have arrived. It multiplies each result by the output gain. It adds the PI channel result into a saturating accumulator. It then registers one control output, chosen by a two-bit mode input: the PD term alone, the accumulated PI term alone, or the sum of the two. All gains are unsigned fixed-point values with four fractional bits. Every scaled quantity is rounded toward minus infinity and clamped to its destination width, so no value ever wraps.

Top module: `fuzzy_pid_dp`

## Requirements
- R1: On a clock edge with `smp_vld` high the block registers error = `setpoint` − `plant_y` (signed, one bit wider than the samples). `req_vld` is high during exactly the cycle that follows each strobe cycle and is low at all other times.
- R2: The error change = current error − previous error. The previous error is zero after reset and is replaced only on a strobe edge.
- R3: `pd_e` = clamp((error × `gain_p`) >>> 4) and `pd_de` = clamp((change × `gain_d`) >>> 4). Here >>> is an arithmetic shift, and clamp limits the value to the signed range of the channel-input width (−128..127 by default).
- R4: `pi_e` uses the same formula as `pd_e`. `pi_de` = clamp((change × `gain_i`) >>> 4).
- R5: Each returned result r gives the term clamp((r × `gain_o`) >>> 4), limited to the signed output width (−32768..32767 by default).
- R6: The accumulator is zero after reset. It is updated exactly once per completed pair of results, to clamp(accumulator + PI term), and is otherwise unchanged.
- R7: With `mode` = 2'b00 the control output is the PD term.
- R8: With `mode` = 2'b01 the control output is the updated accumulator.
- R9: With `mode` = 2'b10 or 2'b11 the control output is clamp(PD term + updated accumulator).
- R10: `u_vld` is high only during the cycle after the one in which the later of the two result strobes arrived. This holds when the two strobes come in either order or in the same cycle. `u_out` keeps its value between completions.
- R11: After reset, `u_out` and the four channel inputs are zero, and `req_vld` and `u_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| setpoint | input | DW | Desired output sample, signed |
| plant_y | input | DW | Measured plant output sample, signed |
| gain_p | input | GW | Proportional gain, unsigned, 4 fraction bits |
| gain_d | input | GW | Derivative gain |
| gain_i | input | GW | Integral gain |
| gain_o | input | GW | Output gain |
| mode | input | 2 | 00 PD, 01 PI, 1x PID |
| req_vld | output | 1 | Channel inputs refreshed |
| pd_e | output | FW | PD channel scaled error |
| pd_de | output | FW | PD channel scaled error change |
| pi_e | output | FW | PI channel scaled error |
| pi_de | output | FW | PI channel scaled error change |
| pd_res | input | RW | PD inference result, signed |
| pd_res_vld | input | 1 | PD result strobe |
| pi_res | input | RW | PI inference result, signed |
| pi_res_vld | input | 1 | PI result strobe |
| u_out | output | OW | Control output, signed |
| u_vld | output | 1 | Control output strobe |

## Verification
The two inference results can land in the same cycle, and the completion logic must then fire once. It must not fire twice, and it must not lose the stored half. The bench randomly chooses, for each sample, whether the PD result comes first, the PI result comes first, or both strobes come together. When one result arrives alone, it checks that `u_vld` stays low. On completion it compares `u_out` and the accumulator effect against a reference model that adds the PI term exactly once. A long run of saturating results, alternating between the ordering cases, also shows that a double update would push the accumulator into its clamp too early.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int FRAC_BITS = 4;

    typedef enum logic [1:0] {
        MODE_PD   = 2'b00,
        MODE_PI   = 2'b01,
        MODE_PIDA = 2'b10,
        MODE_PIDB = 2'b11
    } ctl_mode_e;

    function automatic logic signed [31:0] clamp_s(input logic signed [31:0] v,
                                                   input int w);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (w - 1)) - 32'sd1;
        lo = -hi - 32'sd1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/fpd_scaler.sv
module fpd_scaler #(
    parameter int IW = 10,
    parameter int GW = 8,
    parameter int OW = 8
) (
    input  logic signed [IW-1:0] x,
    input  logic        [GW-1:0] gain,
    output logic signed [OW-1:0] y
);
    import fpd_pkg::*;

    localparam int PW = IW + GW + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic signed [31:0]   clamped;

    always_comb begin
        prod    = x * $signed({1'b0, gain});
        shifted = prod >>> FRAC_BITS;
        clamped = clamp_s(32'(shifted), OW);
        y       = clamped[OW-1:0];
    end

endmodule

// File: rtl/fpd_err_stage.sv
module fpd_err_stage #(
    parameter int DW = 8,
    parameter int GW = 8,
    parameter int FW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] setpoint,
    input  logic signed [DW-1:0] plant_y,
    input  logic        [GW-1:0] gain_p,
    input  logic        [GW-1:0] gain_d,
    input  logic        [GW-1:0] gain_i,
    output logic                 req_vld,
    output logic signed [FW-1:0] pd_e,
    output logic signed [FW-1:0] pd_de,
    output logic signed [FW-1:0] pi_e,
    output logic signed [FW-1:0] pi_de
);
    localparam int EW  = DW + 1;
    localparam int DLW = DW + 2;
    localparam int NCH = 4;

    logic signed [EW-1:0]  err_now;
    logic signed [DLW-1:0] dlt_now;
    logic signed [EW-1:0]  err_q;
    logic signed [EW-1:0]  prev_q;
    logic signed [DLW-1:0] dlt_q;
    logic                  req_q;

    always_comb begin
        err_now = EW'(setpoint) - EW'(plant_y);
        dlt_now = DLW'(err_now) - DLW'(prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            prev_q <= '0;
            dlt_q  <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= smp_vld;
            if (smp_vld) begin
                err_q  <= err_now;
                prev_q <= err_now;
                dlt_q  <= dlt_now;
            end
        end
    end

    assign req_vld = req_q;

    // channel order: pd_e, pd_de, pi_e, pi_de
    logic signed [DLW-1:0] sc_in   [NCH];
    logic        [GW-1:0]  sc_gain [NCH];
    logic signed [FW-1:0]  sc_out  [NCH];

    always_comb begin
        sc_in[0]   = DLW'(err_q);  sc_gain[0] = gain_p;
        sc_in[1]   = dlt_q;        sc_gain[1] = gain_d;
        sc_in[2]   = DLW'(err_q);  sc_gain[2] = gain_p;
        sc_in[3]   = dlt_q;        sc_gain[3] = gain_i;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_scale
        fpd_scaler #(.IW(DLW), .GW(GW), .OW(FW)) u_sc (
            .x    (sc_in[i]),
            .gain (sc_gain[i]),
            .y    (sc_out[i])
        );
    end

    assign pd_e  = sc_out[0];
    assign pd_de = sc_out[1];
    assign pi_e  = sc_out[2];
    assign pi_de = sc_out[3];

    // R1
    req_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        req_q == $past(smp_vld));

    // R2
    prev_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(prev_q));

    // R2
    prev_tracks_err_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> prev_q == err_q);

endmodule

// File: rtl/fpd_join.sv
module fpd_join #(
    parameter int RW = 8,
    parameter int GW = 8,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [RW-1:0] pd_res,
    input  logic                 pd_res_vld,
    input  logic signed [RW-1:0] pi_res,
    input  logic                 pi_res_vld,
    input  logic        [GW-1:0] gain_o,
    input  logic        [1:0]    mode,
    output logic signed [OW-1:0] u_out,
    output logic                 u_vld
);
    import fpd_pkg::*;

    logic signed [RW-1:0] pd_h, pi_h;
    logic                 pd_got, pi_got;
    logic signed [RW-1:0] pd_sel, pi_sel;
    logic                 fire;
    logic signed [OW-1:0] pd_term, pi_term;
    logic signed [OW-1:0] acc_q, acc_nxt;
    logic signed [OW:0]   acc_sum, pid_sum;
    logic signed [OW-1:0] u_nxt, u_q;
    logic signed [31:0]   acc_c, pid_c;
    logic                 uv_q;
    ctl_mode_e            md;

    always_comb begin
        pd_sel = pd_res_vld ? pd_res : pd_h;
        pi_sel = pi_res_vld ? pi_res : pi_h;
        fire   = (pd_got | pd_res_vld) & (pi_got | pi_res_vld);
    end

    fpd_scaler #(.IW(RW), .GW(GW), .OW(OW)) u_pd_sc (
        .x (pd_sel), .gain (gain_o), .y (pd_term));

    fpd_scaler #(.IW(RW), .GW(GW), .OW(OW)) u_pi_sc (
        .x (pi_sel), .gain (gain_o), .y (pi_term));

    always_comb begin
        md      = ctl_mode_e'(mode);
        acc_sum = (OW+1)'(acc_q) + (OW+1)'(pi_term);
        acc_c   = clamp_s(32'(acc_sum), OW);
        acc_nxt = acc_c[OW-1:0];
        pid_sum = (OW+1)'(pd_term) + (OW+1)'(acc_nxt);
        pid_c   = clamp_s(32'(pid_sum), OW);
        case (md)
            MODE_PD: u_nxt = pd_term;
            MODE_PI: u_nxt = acc_nxt;
            default: u_nxt = pid_c[OW-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_h   <= '0;
            pi_h   <= '0;
            pd_got <= 1'b0;
            pi_got <= 1'b0;
            acc_q  <= '0;
            u_q    <= '0;
            uv_q   <= 1'b0;
        end else begin
            if (pd_res_vld) pd_h <= pd_res;
            if (pi_res_vld) pi_h <= pi_res;
            pd_got <= fire ? 1'b0 : (pd_got | pd_res_vld);
            pi_got <= fire ? 1'b0 : (pi_got | pi_res_vld);
            uv_q   <= fire;
            if (fire) begin
                acc_q <= acc_nxt;
                u_q   <= u_nxt;
            end
        end
    end

    assign u_out = u_q;
    assign u_vld = uv_q;

    // R10
    valid_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        uv_q |-> ($past(pd_res_vld || pd_got) && $past(pi_res_vld || pi_got)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(u_q));

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(acc_q));

    // R8
    pi_mode_out_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == 2'b01) |=> u_q == acc_q);

endmodule

// File: rtl/fuzzy_pid_dp.sv
module fuzzy_pid_dp #(
    parameter int DW = 8,
    parameter int GW = 8,
    parameter int FW = 8,
    parameter int RW = 8,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] setpoint,
    input  logic signed [DW-1:0] plant_y,
    input  logic        [GW-1:0] gain_p,
    input  logic        [GW-1:0] gain_d,
    input  logic        [GW-1:0] gain_i,
    input  logic        [GW-1:0] gain_o,
    input  logic        [1:0]    mode,
    output logic                 req_vld,
    output logic signed [FW-1:0] pd_e,
    output logic signed [FW-1:0] pd_de,
    output logic signed [FW-1:0] pi_e,
    output logic signed [FW-1:0] pi_de,
    input  logic signed [RW-1:0] pd_res,
    input  logic                 pd_res_vld,
    input  logic signed [RW-1:0] pi_res,
    input  logic                 pi_res_vld,
    output logic signed [OW-1:0] u_out,
    output logic                 u_vld
);

    fpd_err_stage #(.DW(DW), .GW(GW), .FW(FW)) u_err (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .setpoint (setpoint),
        .plant_y  (plant_y),
        .gain_p   (gain_p),
        .gain_d   (gain_d),
        .gain_i   (gain_i),
        .req_vld  (req_vld),
        .pd_e     (pd_e),
        .pd_de    (pd_de),
        .pi_e     (pi_e),
        .pi_de    (pi_de)
    );

    fpd_join #(.RW(RW), .GW(GW), .OW(OW)) u_join (
        .clk        (clk),
        .rst        (rst),
        .pd_res     (pd_res),
        .pd_res_vld (pd_res_vld),
        .pi_res     (pi_res),
        .pi_res_vld (pi_res_vld),
        .gain_o     (gain_o),
        .mode       (mode),
        .u_out      (u_out),
        .u_vld      (u_vld)
    );

endmodule

// File: tb/fuzzy_pid_dp_tb.sv
`timescale 1ns/1ps
module fuzzy_pid_dp_tb;

    localparam int DW = 8, GW = 8, FW = 8, RW = 8, OW = 16;

    logic clk = 1'b0;
    logic rst;
    logic smp_vld;
    logic signed [DW-1:0] setpoint, plant_y;
    logic [GW-1:0] gain_p, gain_d, gain_i, gain_o;
    logic [1:0] mode;
    logic req_vld;
    logic signed [FW-1:0] pd_e, pd_de, pi_e, pi_de;
    logic signed [RW-1:0] pd_res, pi_res;
    logic pd_res_vld, pi_res_vld;
    logic signed [OW-1:0] u_out;
    logic u_vld;

    always #2.5 clk = ~clk;

    fuzzy_pid_dp #(.DW(DW), .GW(GW), .FW(FW), .RW(RW), .OW(OW)) u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .setpoint(setpoint),
        .plant_y(plant_y), .gain_p(gain_p), .gain_d(gain_d), .gain_i(gain_i),
        .gain_o(gain_o), .mode(mode), .req_vld(req_vld), .pd_e(pd_e),
        .pd_de(pd_de), .pi_e(pi_e), .pi_de(pi_de), .pd_res(pd_res),
        .pd_res_vld(pd_res_vld), .pi_res(pi_res), .pi_res_vld(pi_res_vld),
        .u_out(u_out), .u_vld(u_vld));

    int n_chk = 0;
    int n_bad = 0;
    int prev_m = 0;
    int acc_m = 0;
    int u_m = 0;
    bit done = 0;

    function automatic int sat(int v, int w);
        int hi;
        hi = (1 <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    function automatic int scl(int x, int g, int w);
        return sat((x * g) >>> 4, w);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // order: 0 together, 1 PD first, 2 PI first
    task automatic run_vec(int sp, int y, int kp, int kd, int ki, int ko,
                           int md, int pdr, int pir, int order);
        int e, de, pdt, pit;
        @(negedge clk);
        setpoint = DW'(sp); plant_y = DW'(y);
        gain_p = GW'(kp); gain_d = GW'(kd); gain_i = GW'(ki); gain_o = GW'(ko);
        mode = 2'(md);
        smp_vld = 1'b1;
        @(posedge clk); #1;
        e = sp - y; de = e - prev_m; prev_m = e;
        chk("R1 req_vld", int'(req_vld), 1);
        chk("R3 pd_e", int'(pd_e), scl(e, kp, FW));
        chk("R3 pd_de", int'(pd_de), scl(de, kd, FW));
        chk("R4 pi_e", int'(pi_e), scl(e, kp, FW));
        chk("R4 pi_de", int'(pi_de), scl(de, ki, FW));
        @(negedge clk);
        smp_vld = 1'b0;
        if (order == 0) begin
            pd_res = RW'(pdr); pi_res = RW'(pir);
            pd_res_vld = 1'b1; pi_res_vld = 1'b1;
        end else begin
            if (order == 1) begin pd_res = RW'(pdr); pd_res_vld = 1'b1; end
            else            begin pi_res = RW'(pir); pi_res_vld = 1'b1; end
            @(posedge clk); #1;
            chk("R1 req_vld low", int'(req_vld), 0);
            chk("R10 no valid on half", int'(u_vld), 0);
            chk("R10 output held", int'(u_out), u_m);
            @(negedge clk);
            pd_res_vld = 1'b0; pi_res_vld = 1'b0;
            pd_res = '0; pi_res = '0;
            @(negedge clk);
            if (order == 1) begin pi_res = RW'(pir); pi_res_vld = 1'b1; end
            else            begin pd_res = RW'(pdr); pd_res_vld = 1'b1; end
        end
        @(posedge clk); #1;
        pdt = scl(pdr, ko, OW);
        pit = scl(pir, ko, OW);
        acc_m = sat(acc_m + pit, OW);
        if (md == 0)      u_m = pdt;
        else if (md == 1) u_m = acc_m;
        else              u_m = sat(pdt + acc_m, OW);
        chk("R10 u_vld", int'(u_vld), 1);
        if (md == 0)      chk("R7 PD out", int'(u_out), u_m);
        else if (md == 1) chk("R8 PI out R6 R5", int'(u_out), u_m);
        else              chk("R9 PID out R6 R5", int'(u_out), u_m);
        @(negedge clk);
        pd_res_vld = 1'b0; pi_res_vld = 1'b0;
        @(posedge clk); #1;
        chk("R10 single pulse", int'(u_vld), 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst = 1'b1; smp_vld = 0; setpoint = '0; plant_y = '0;
        gain_p = '0; gain_d = '0; gain_i = '0; gain_o = '0; mode = '0;
        pd_res = '0; pi_res = '0; pd_res_vld = 0; pi_res_vld = 0;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 u_out", int'(u_out), 0);
        chk("R11 u_vld", int'(u_vld), 0);
        chk("R11 req_vld", int'(req_vld), 0);
        chk("R11 pd_e", int'(pd_e), 0);
        chk("R11 pi_de", int'(pi_de), 0);
        @(negedge clk); rst = 1'b0;

        // R2 first change after reset equals error; R3 clamp at max
        run_vec(127, -128, 255, 255, 255, 16, 0, 10, 0, 0);
        // R2 change with opposite extreme; R3 negative clamp
        run_vec(-128, 127, 255, 255, 16, 16, 1, -5, 3, 1);
        // R6 accumulator saturation with mixed orderings, R9 sum clamp
        for (int k = 0; k < 20; k++)
            run_vec(1, 0, 16, 16, 16, 255, 2 + (k % 2), 127, 127, k % 3);
        for (int k = 0; k < 3; k++)
            run_vec(0, 0, 16, 16, 16, 255, 1, 0, -128, k);
        // R2 previous error held between strobes: idle cycles, then repeat
        repeat (5) @(posedge clk);
        run_vec(0, 0, 16, 16, 16, 16, 0, 0, 0, 0);
        // random vectors
        for (int k = 0; k < 150; k++)
            run_vec($signed(8'($urandom)), $signed(8'($urandom)),
                    int'(8'($urandom)), int'(8'($urandom)),
                    int'(8'($urandom)), int'(8'($urandom)),
                    int'($urandom % 4),
                    $signed(8'($urandom)), $signed(8'($urandom)),
                    int'($urandom % 3));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule